// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block lets synchronous logic read and write an external asynchronous static RAM that is 128K words deep and 8 bits wide, with one shared bidirectional data bus. The user side is a simple request port. A strobe arrives with a read/write flag, a 17-bit word address and write data. The port answers with a ready flag, plus read data qualified by a one-cycle valid pulse.

On the memory side the controller drives the address, a low-active and a high-active chip enable, a low-active output enable and a low-active write enable. It also owns a tri-state data bus. The controller has no asynchronous timing logic. Every strobe width and every gap is a whole number of clock cycles, rounded up from the memory's nanosecond limits, which are given as parameters in picoseconds together with the clock period. With the default 5 ns clock the counts are a 3-cycle read window, a 3-cycle write pulse and a 2-cycle bus-release wait.

Every pin is driven from a register. A read takes 3 + 1 + 2 = 6 busy cycles. A write takes 1 + 3 + 1 = 5 busy cycles. One idle cycle always follows, in which the ready flag is high and the pins are inactive.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, ready is 1, rvalid is 0, mem_ce1_n is 1, mem_ce2 is 0, mem_oe_n is 1 and mem_we_n is 1.
- R2: The two chip enables always carry opposite levels (mem_ce2 equals the inverse of mem_ce1_n). A read holds mem_ce1_n=0, mem_ce2=1, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles, where RD_CYC = max(ceil(T_ACCESS_PS/CLK_PERIOD_PS), ceil(T_OE_PS/CLK_PERIOD_PS)).
- R3: Read data is sampled from mem_dq at the clock edge that ends the RD_CYC-th enabled cycle. It appears on rdata with rvalid high for exactly one cycle, beginning RD_CYC cycles after the edge that accepted the request.
- R4: A write has three phases. First comes one setup cycle with the chips enabled and mem_we_n=1. Next, mem_we_n is held at 0 for exactly WP_CYC consecutive cycles, where WP_CYC = max(ceil(T_WPULSE_PS/period), ceil(T_DSETUP_PS/period)). Last comes one recovery cycle with mem_we_n=1 and the chips still enabled. The data on mem_dq at the rising edge of mem_we_n is the accepted write data.
- R5: The controller drives mem_dq only during the three write phases. It never drives it while mem_oe_n is 0, and mem_we_n is never 0 while mem_oe_n is 0.
- R6: After a read, mem_oe_n stays high for at least TA_CYC + 1 cycles before the chips are enabled for a following write, where TA_CYC = ceil(T_BUSREL_PS/period).
- R7: Ready falls at the accepting edge. It stays low for RD_CYC + 1 + TA_CYC cycles for a read and WP_CYC + 2 cycles for a write, then returns high.
- R8: A request strobe seen while ready is low has no effect. The address pins, the cycle length and the memory contents are unchanged by it.
- R9: mem_addr changes only on the edge that enables the chips for a new cycle. It equals the accepted address at that point and holds for as long as the chip enables stay active.
- R10: Write data is captured at acceptance. Later changes on req_wdata during the write do not change what is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken only while ready is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | High when a new request is accepted |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | One-cycle qualifier for rdata |
| mem_addr | output | 17 | Memory address |
| mem_ce1_n | output | 1 | Low-active chip enable |
| mem_ce2 | output | 1 | High-active chip enable |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_we_n | output | 1 | Low-active write enable |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The memory model in the bench puts the complement of the stored byte on the bus until RD_CYC cycles have passed since the chips were enabled for a read. A controller that samples one edge early therefore returns wrong data rather than passing by accident.

The bench measures the exact length of the write-enable pulse and how long output enable stays high before a write directly follows a read. A pulse that is too short, or a missing turnaround wait, shows up as a wrong count.

Several requests are injected in the middle of a cycle. If the controller accepted one, the address on the pins would jump or a neighbouring location would be overwritten.

The bench also changes req_wdata during a write. A controller that forwards the live input instead of the captured value stores the changed byte, and the read-back check catches it.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE          = 3'd0,
    ST_READ_ACCESS   = 3'd1,
    ST_READ_DONE     = 3'd2,
    ST_WRITE_SETUP   = 3'd3,
    ST_WRITE_PULSE   = 3'd4,
    ST_WRITE_RECOVER = 3'd5,
    ST_TURNAROUND    = 3'd6
  } sram_state_e;

  // Whole cycles covering a time span, never less than one.
  function automatic int cycles_for(input int span_ps, input int period_ps);
    int c;
    c = (span_ps + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_port_pkg::*;
#(
  parameter int RD_CYC = 3,
  parameter int WP_CYC = 3,
  parameter int TA_CYC = 2,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             tdone,
  output sram_state_e      state,
  output sram_state_e      state_nxt,
  output logic             tload,
  output logic [CNT_W-1:0] tload_val
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  sram_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end

  always_comb begin
    state_nxt = state_q;
    tload     = 1'b0;
    tload_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (req_wr) begin
            state_nxt = ST_WRITE_SETUP;
          end else begin
            state_nxt = ST_READ_ACCESS;
            tload     = 1'b1;
            tload_val = RD_LOAD;
          end
        end
      end
      ST_READ_ACCESS: if (tdone) state_nxt = ST_READ_DONE;
      ST_READ_DONE: begin
        state_nxt = ST_TURNAROUND;
        tload     = 1'b1;
        tload_val = TA_LOAD;
      end
      ST_TURNAROUND: if (tdone) state_nxt = ST_IDLE;
      ST_WRITE_SETUP: begin
        state_nxt = ST_WRITE_PULSE;
        tload     = 1'b1;
        tload_val = WP_LOAD;
      end
      ST_WRITE_PULSE:   if (tdone) state_nxt = ST_WRITE_RECOVER;
      ST_WRITE_RECOVER: state_nxt = ST_IDLE;
      default:          state_nxt = ST_IDLE;
    endcase
  end

  assign state = state_q;

endmodule

// File: rtl/sram_pin_driver.sv
module sram_pin_driver
  import sram_port_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sram_state_e       state,
  input  sram_state_e       state_nxt,
  input  logic              accept,
  input  logic              tdone,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);

  logic nxt_read, nxt_write, nxt_pulse, capture;

  assign nxt_read  = (state_nxt == ST_READ_ACCESS);
  assign nxt_pulse = (state_nxt == ST_WRITE_PULSE);
  assign nxt_write = (state_nxt == ST_WRITE_SETUP) || nxt_pulse ||
                     (state_nxt == ST_WRITE_RECOVER);
  assign capture   = (state == ST_READ_ACCESS) && tdone;

  // Control strobes: decoded from the next state, so every pin is a flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b1;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      ready     <= (state_nxt == ST_IDLE);
      mem_ce1_n <= !(nxt_read || nxt_write);
      mem_ce2   <=  (nxt_read || nxt_write);
      mem_oe_n  <= !nxt_read;
      mem_we_n  <= !nxt_pulse;
      dq_oe     <= nxt_write;
    end
  end

  // Address and write data are taken once, on the accepting edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= in_addr;
      dq_out   <= in_wdata;
    end
  end

  // Read return path.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int T_ACCESS_PS   = 15000,
  parameter int T_OE_PS       = 8000,
  parameter int T_WPULSE_PS   = 12000,
  parameter int T_DSETUP_PS   = 7000,
  parameter int T_BUSREL_PS   = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int RD_CYC  = max2(cycles_for(T_ACCESS_PS, CLK_PERIOD_PS),
                                cycles_for(T_OE_PS, CLK_PERIOD_PS));
  localparam int WP_CYC  = max2(cycles_for(T_WPULSE_PS, CLK_PERIOD_PS),
                                cycles_for(T_DSETUP_PS, CLK_PERIOD_PS));
  localparam int TA_CYC  = cycles_for(T_BUSREL_PS, CLK_PERIOD_PS);
  localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), TA_CYC);
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  sram_state_e       state, state_nxt;
  logic              tload, tdone, accept, dq_oe;
  logic [CNT_W-1:0]  tload_val;
  logic [DATA_W-1:0] dq_out;

  assign accept = req && (state == ST_IDLE);

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .req_wr    (req_wr),
    .tdone     (tdone),
    .state     (state),
    .state_nxt (state_nxt),
    .tload     (tload),
    .tload_val (tload_val)
  );

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tload),
    .load_val (tload_val),
    .done     (tdone)
  );

  sram_pin_driver #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .state_nxt (state_nxt),
    .accept    (accept),
    .tdone     (tdone),
    .in_addr   (req_addr),
    .in_wdata  (req_wdata),
    .dq_in     (mem_dq),
    .ready     (ready),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out)
  );

  assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              ready,
  input logic              rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              dq_oe
);

  AST_CE_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
    mem_ce2 == !mem_ce1_n);                                             // R2

  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);                                                // R3

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n));                 // R4

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> mem_oe_n);                                                // R5

  AST_BUSY_WHILE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    !mem_ce1_n |-> !ready);                                             // R7

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (ready && req) |=> !ready);                                         // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));           // R9

endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .ready     (ready),
  .rvalid    (rvalid),
  .mem_addr  (mem_addr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .dq_oe     (dq_oe)
);

// File: tb/sram_port_ctrl_bench.sv
`timescale 1ns/1ps
module sram_port_ctrl_bench;

  // Counts derived here from the timing limits at a 5 ns clock.
  localparam int RD = 3;  // max(ceil(15/5), ceil(8/5))
  localparam int WP = 3;  // max(ceil(12/5), ceil(7/5))
  localparam int TA = 2;  // ceil(8/5)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rvalid, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  wire  [7:0]  mem_dq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sram_port_ctrl u_sram_port_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  // Memory model: 256 locations indexed by the low address byte.
  logic [7:0] mdl [0:255];
  logic       m_drive;
  logic [3:0] age = '0;
  logic [7:0] m_word;

  assign m_drive = !mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n;
  assign m_word  = mdl[mem_addr[7:0]];
  assign mem_dq  = m_drive ? ((age >= 4'(RD - 1)) ? m_word : ~m_word) : 8'hzz;

  always @(posedge clk) age <= m_drive ? ((age == 4'hF) ? age : age + 4'd1) : 4'd0;

  // Pin monitors, sampled at the falling edge.
  logic [16:0] wr_a;
  logic [7:0]  wr_d;
  logic        we_prev = 1'b1, ce_prev_low = 1'b0;
  int          we_run = 0, last_we_run = 0, oe_hi = 1000, min_gap = 1000;
  int          bad_pair = 0, bad_oe_we = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_ce2 == mem_ce1_n) bad_pair++;
      if (!mem_oe_n && !mem_we_n) bad_oe_we++;
      if (!mem_we_n) begin
        wr_a = mem_addr;
        wr_d = mem_dq;
        we_run++;
      end
      if (!we_prev && mem_we_n) begin
        if (!mem_ce1_n && mem_ce2) mdl[wr_a[7:0]] = wr_d;
        last_we_run = we_run;
        we_run = 0;
      end
      if (!mem_ce1_n && !ce_prev_low && mem_oe_n && oe_hi < min_gap) min_gap = oe_hi;
      if (!mem_oe_n) oe_hi = 0; else if (oe_hi < 1000) oe_hi++;
      we_prev = mem_we_n;
      ce_prev_low = !mem_ce1_n;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit wiggle);
    int done_at = 0;
    @(negedge clk);
    req = 1; req_wr = 1; req_addr = a; req_wdata = d;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      req = 0;
      if (wiggle) req_wdata = ~d ^ 8'(n);
      if (n == 1) chk(mem_addr == a && !mem_ce1_n, "R9 addr with enable", int'(mem_addr), int'(a));
      if (n == 1) chk(mem_we_n == 1'b1, "R4 setup cycle WE high", int'(mem_we_n), 1);
      if (ready) begin done_at = n; break; end
    end
    chk(done_at == WP + 3, "R7 write busy length", done_at, WP + 3);
    chk(last_we_run == WP, "R4 write pulse cycles", last_we_run, WP);
    chk(mdl[a[7:0]] == d, wiggle ? "R10 stored captured data" : "R4 stored data",
        int'(mdl[a[7:0]]), int'(d));
  endtask

  task automatic do_read(input logic [16:0] a, input logic [7:0] exp, input bit intrude);
    int done_at = 0, rv_at = 0, rv_cnt = 0, oe_cyc = 0;
    logic [7:0] got = '0;
    bit addr_ok = 1;
    @(negedge clk);
    req = 1; req_wr = 0; req_addr = a;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      req = 0;
      if (intrude && n == 2) begin
        req = 1; req_wr = 1; req_addr = a ^ 17'h1; req_wdata = 8'hFF;
      end
      if (!mem_oe_n) oe_cyc++;
      if (!mem_ce1_n && mem_addr != a) addr_ok = 0;
      if (rvalid) begin rv_cnt++; rv_at = n; got = rdata; end
      if (ready) begin done_at = n; break; end
    end
    req = 0;
    chk(oe_cyc == RD, "R2 read enable cycles", oe_cyc, RD);
    chk(rv_at == RD + 1 && rv_cnt == 1, "R3 rvalid timing", rv_at, RD + 1);
    chk(got == exp, "R3 read data", int'(got), int'(exp));
    chk(done_at == RD + 2 + TA, "R7 read busy length", done_at, RD + 2 + TA);
    chk(addr_ok, intrude ? "R8 address kept under stray request" : "R9 address held",
        int'(addr_ok), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);
    chk(rvalid == 1'b0, "R1 rvalid", int'(rvalid), 0);
    chk(mem_ce1_n == 1'b1 && mem_ce2 == 1'b0, "R1 enables off", int'({mem_ce1_n, mem_ce2}), 2);
    chk(mem_oe_n == 1'b1 && mem_we_n == 1'b1, "R1 strobes high", int'({mem_oe_n, mem_we_n}), 3);
  endtask

  task automatic t_patterns();
    do_write(17'h00012, 8'h3C, 0);
    do_write(17'h1FF34, 8'hA5, 0);
    do_write(17'h00000, 8'h00, 0);
    do_write(17'h1FFFF, 8'hFF, 0);
    do_read(17'h00012, 8'h3C, 0);
    do_read(17'h1FF34, 8'hA5, 0);
    do_read(17'h00000, 8'h00, 0);
    do_read(17'h1FFFF, 8'hFF, 0);
  endtask

  task automatic t_stray_request();
    do_write(17'h00040, 8'h11, 0);
    do_write(17'h00041, 8'h22, 0);
    do_read(17'h00040, 8'h11, 1);
    do_read(17'h00041, 8'h22, 0);   // R8: neighbour untouched
  endtask

  task automatic t_wdata_change();
    do_write(17'h00077, 8'h5A, 1);
    do_read(17'h00077, 8'h5A, 0);   // R10
  endtask

  task automatic t_turnaround();
    min_gap = 1000;
    do_read(17'h00012, 8'h3C, 0);
    do_write(17'h00013, 8'h69, 0);
    chk(min_gap >= TA + 1, "R6 read to write gap", min_gap, TA + 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    t_reset();
    t_patterns();
    t_stray_request();
    t_wdata_change();
    t_turnaround();
    repeat (3) @(negedge clk);
    chk(bad_pair == 0, "R2 enable pair opposite", bad_pair, 0);
    chk(bad_oe_we == 0, "R5 write never under output enable", bad_oe_we, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule